// File: doc/BRIEF.md
# SMBus Special Address and Alert Logic

This block sits next to an I2C target engine and adds the SMBus-specific parts of address recognition and alert signalling. Each time the engine receives a 7-bit address, it pulses a strobe. One cycle later the block returns a match flag and a code that says which kind of address matched. The engine uses the match flag to decide whether to acknowledge.

The block compares the received address against four candidates:
- the programmed own address,
- the fixed device default address 7'b1100001,
- the fixed host address 7'b0001000,
- the fixed alert response address 7'b0001100.

Each candidate has its own enable condition.

The alert path works differently in the two modes.
- **Device mode:** enabling alerts drives the open-drain alert line low. It also makes the block answer the alert response address.
- **Host mode:** the block never drives the line. It watches the line instead, and a falling edge sets a sticky status flag, which can raise an interrupt.

Top module: `smb_addr_alert`

## Requirements
- R1: With `own_en_i`=1, a strobed address equal to `own_addr_i` gives `match_o`=1 and `match_kind_o`=1 one cycle after the strobe; with `own_en_i`=0 it does not.
- R2: With `dflt_en_i`=1, address 7'b1100001 matches with kind 2; with `dflt_en_i`=0 it gives no default match.
- R3: With `host_mode_i`=1, address 7'b0001000 matches with kind 3; in device mode it gives no host match.
- R4: Address 7'b0001100 matches with kind 4 only when `host_mode_i`=0 and `alert_en_i`=1, which is exactly when the block is pulling the alert line low.
- R5: `match_valid_o` pulses for exactly one cycle, one cycle after each `addr_valid_i`. When `match_valid_o`=0, `match_o`=0 and `match_kind_o`=0. Kind 0 means no match. An own-address match takes priority over every fixed address.
- R6: `smba_drive_o` equals the previous cycle's (`host_mode_i`=0 and `alert_en_i`=1). The drive therefore holds until software clears the enable, and it is never asserted in host mode.
- R7: In host mode with `alert_en_i`=1, a falling edge on `smba_i` sets `alert_flag_o` three cycles after the pin falls. This path uses a two-stage synchronizer. Setting `alert_en_i` while the synchronized pin is already low counts as a falling edge.
- R8: With `alert_en_i`=0 the internal alert line is treated as high, whatever the pin level, and `alert_flag_o` never sets.
- R9: `alert_flag_o` stays set until a cycle with `alert_clr_i`=1. If a set and a clear land in the same cycle, the set wins.
- R10: `irq_o` equals `alert_flag_o` AND the previous cycle's `err_irq_en_i`.
- R11: After synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid_i | input | 1 | Strobe: received address is present |
| addr_i | input | 7 | Received 7-bit address |
| own_addr_i | input | 7 | Programmed own address |
| own_en_i | input | 1 | Enable own-address compare |
| dflt_en_i | input | 1 | Enable device default address |
| host_mode_i | input | 1 | 1 = host mode, 0 = device mode |
| alert_en_i | input | 1 | Alert enable |
| err_irq_en_i | input | 1 | Interrupt enable for the alert flag |
| alert_clr_i | input | 1 | Write-1-to-clear pulse for the alert flag |
| smba_i | input | 1 | Alert line level (asynchronous) |
| match_valid_o | output | 1 | Match result valid pulse |
| match_o | output | 1 | Address matched |
| match_kind_o | output | 3 | 0 none, 1 own, 2 default, 3 host, 4 alert response |
| smba_drive_o | output | 1 | Open-drain pull-low enable for the alert line |
| alert_flag_o | output | 1 | Sticky alert status |
| irq_o | output | 1 | Alert interrupt |

## Verification
The hardest situations to reach from the ports are those where several alert events fall into the same cycle.

One is the alert edge coinciding with a clear pulse. This needs the clear timed to the third edge after the pin falls. Another is the edge that comes from enabling alerts while the line is already low. Directed sequences step the pin, the enable and the clear pulse cycle by cycle to hit both cases.

A long seeded random run then mixes three things: pin toggles, mode and enable changes, and strobed addresses biased toward the four candidates. Every cycle is compared against a bench reference model.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_OWN   = 3'd1,
    KIND_DFLT  = 3'd2,
    KIND_HOST  = 3'd3,
    KIND_ALERT = 3'd4
  } match_kind_t;

  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] DFLT_ADDR  = 7'b1100001;
  localparam logic [ADDR_W-1:0] HOST_ADDR  = 7'b0001000;
  localparam logic [ADDR_W-1:0] ALERT_ADDR = 7'b0001100;
endpackage

// File: rtl/smb_addr_decode.sv
module smb_addr_decode
  import smb_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          own_en_i,
  input  logic          dflt_en_i,
  input  logic          host_mode_i,
  input  logic          ara_en_i,
  output logic          match_valid_o,
  output logic          match_o,
  output match_kind_t   kind_o
);
  match_kind_t kind_d;

  // Own address is checked first, so it wins over every fixed address.
  always_comb begin
    kind_d = KIND_NONE;
    if (own_en_i && addr_i == own_addr_i)            kind_d = KIND_OWN;
    else if (dflt_en_i && addr_i == DFLT_ADDR)       kind_d = KIND_DFLT;
    else if (host_mode_i && addr_i == HOST_ADDR)     kind_d = KIND_HOST;
    else if (ara_en_i && addr_i == ALERT_ADDR)       kind_d = KIND_ALERT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid_o <= 1'b0;
      match_o       <= 1'b0;
      kind_o        <= KIND_NONE;
    end else begin
      match_valid_o <= addr_valid_i;
      match_o       <= addr_valid_i && (kind_d != KIND_NONE);
      kind_o        <= addr_valid_i ? kind_d : KIND_NONE;
    end
  end

  assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !match_valid_o |-> (!match_o && kind_o == KIND_NONE));
  assert_default_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && !dflt_en_i |=> kind_o != KIND_DFLT);
  assert_host_needs_mode_R3: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && !host_mode_i |=> kind_o != KIND_HOST);
endmodule

// File: rtl/smb_alert_sync.sv
module smb_alert_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic enable_i,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              gated;
  logic              gated_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= pin_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  // A disabled alert is seen as an idle (high) line.
  assign gated = sync_q[LAST] | ~enable_i;

  always_ff @(posedge clk) begin
    if (rst) gated_q <= 1'b1;
    else     gated_q <= gated;
  end

  assign fall_o = gated_q & ~gated;

  assert_no_edge_when_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !enable_i |-> !fall_o);
endmodule

// File: rtl/smb_alert_status.sv
module smb_alert_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      irq_o  <= flag_d & irq_en_i;
    end
  end

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    flag_o && !clr_i |=> flag_o);
  assert_irq_implies_flag_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
endmodule

// File: rtl/smb_addr_alert.sv
module smb_addr_alert
  import smb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              own_en_i,
  input  logic              dflt_en_i,
  input  logic              host_mode_i,
  input  logic              alert_en_i,
  input  logic              err_irq_en_i,
  input  logic              alert_clr_i,
  input  logic              smba_i,
  output logic              match_valid_o,
  output logic              match_o,
  output logic [2:0]        match_kind_o,
  output logic              smba_drive_o,
  output logic              alert_flag_o,
  output logic              irq_o
);
  logic        dev_alert;
  logic        host_alert_en;
  logic        alert_fall;
  match_kind_t kind;

  assign dev_alert     = ~host_mode_i & alert_en_i;
  assign host_alert_en = host_mode_i & alert_en_i;

  smb_addr_decode #(.AW(ADDR_W)) u_decode (
    .clk          (clk),
    .rst          (rst),
    .addr_valid_i (addr_valid_i),
    .addr_i       (addr_i),
    .own_addr_i   (own_addr_i),
    .own_en_i     (own_en_i),
    .dflt_en_i    (dflt_en_i),
    .host_mode_i  (host_mode_i),
    .ara_en_i     (dev_alert),
    .match_valid_o(match_valid_o),
    .match_o      (match_o),
    .kind_o       (kind)
  );
  assign match_kind_o = kind;

  // Pull-low drive is held while the device-mode enable stays set.
  always_ff @(posedge clk) begin
    if (rst) smba_drive_o <= 1'b0;
    else     smba_drive_o <= dev_alert;
  end

  smb_alert_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (smba_i),
    .enable_i (host_alert_en),
    .fall_o   (alert_fall)
  );

  smb_alert_status u_status (
    .clk      (clk),
    .rst      (rst),
    .set_i    (alert_fall),
    .clr_i    (alert_clr_i),
    .irq_en_i (err_irq_en_i),
    .flag_o   (alert_flag_o),
    .irq_o    (irq_o)
  );

  assert_no_drive_in_host_R6: assert property (@(posedge clk) disable iff (rst)
    host_mode_i |=> !smba_drive_o);
  assert_ara_only_when_pulling_R4: assert property (@(posedge clk) disable iff (rst)
    match_kind_o == 3'd4 |-> smba_drive_o);
  assert_flag_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_flag_o) |-> $past(alert_en_i));
endmodule

// File: tb/smb_addr_alert_tb.sv
module smb_addr_alert_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_valid = 1'b0;
  logic [6:0] addr = '0, own_addr = 7'h2a;
  logic own_en = 0, dflt_en = 0, host_mode = 0, alert_en = 0, errie = 0, clr = 0, pin = 1;
  logic mv, m, drive, flag, irq;
  logic [2:0] kind;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smb_addr_alert u_dut (
    .clk(clk), .rst(rst), .addr_valid_i(addr_valid), .addr_i(addr),
    .own_addr_i(own_addr), .own_en_i(own_en), .dflt_en_i(dflt_en),
    .host_mode_i(host_mode), .alert_en_i(alert_en), .err_irq_en_i(errie),
    .alert_clr_i(clr), .smba_i(pin), .match_valid_o(mv), .match_o(m),
    .match_kind_o(kind), .smba_drive_o(drive), .alert_flag_o(flag), .irq_o(irq)
  );

  // Reference model built from the requirements.
  logic r_s1 = 1, r_s2 = 1, r_prev = 1, r_flag = 0, r_irq = 0, r_drive = 0, r_mv = 0, r_m = 0;
  logic [2:0] r_kind = 0;

  function automatic logic [2:0] exp_kind(logic [6:0] a, logic [6:0] own, logic oe, logic de,
                                          logic hm, logic ae);
    if (oe && a == own) return 3'd1;
    if (de && a == 7'b1100001) return 3'd2;
    if (hm && a == 7'b0001000) return 3'd3;
    if (!hm && ae && a == 7'b0001100) return 3'd4;
    return 3'd0;
  endfunction

  always @(posedge clk) begin
    logic g, f, nf;
    if (rst) begin
      r_s1 = 1; r_s2 = 1; r_prev = 1; r_flag = 0; r_irq = 0; r_drive = 0;
      r_mv = 0; r_m = 0; r_kind = 0;
    end else begin
      g  = r_s2 | ~(host_mode & alert_en);
      f  = r_prev & ~g;
      nf = f ? 1'b1 : (clr ? 1'b0 : r_flag);
      r_flag = nf; r_irq = nf & errie;
      r_prev = g; r_s2 = r_s1; r_s1 = pin;
      r_drive = ~host_mode & alert_en;
      r_mv = addr_valid;
      r_kind = addr_valid ? exp_kind(addr, own_addr, own_en, dflt_en, host_mode, alert_en) : 3'd0;
      r_m = (r_kind != 0);
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string kind_req(logic [2:0] k);
    case (k)
      3'd1: return "R1 own";
      3'd2: return "R2 default";
      3'd3: return "R3 host";
      3'd4: return "R4 alert-response";
      default: return "R5 none";
    endcase
  endfunction

  task automatic compare_all();
    chk("R5 match_valid", {7'd0, mv}, {7'd0, r_mv});
    chk("R5 match", {7'd0, m}, {7'd0, r_m});
    chk(kind_req(r_kind), {5'd0, kind}, {5'd0, r_kind});
    chk("R6 drive", {7'd0, drive}, {7'd0, r_drive});
    chk(alert_en ? "R7 flag" : "R8 flag", {7'd0, flag}, {7'd0, r_flag});
    chk("R10 irq", {7'd0, irq}, {7'd0, r_irq});
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic strobe(logic [6:0] a);
    addr = a; addr_valid = 1; step(); addr_valid = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset match_valid", {7'd0, mv}, 0);
    chk("R11 reset kind", {5'd0, kind}, 0);
    chk("R11 reset drive/flag/irq", {5'd0, drive, flag, irq}, 0);

    // R1 own vs R2 default priority: own address set to default address
    own_en = 1; dflt_en = 1; own_addr = 7'b1100001;
    strobe(7'b1100001); chk("R5 own priority", {5'd0, kind}, 1);
    own_addr = 7'h2a;
    strobe(7'b1100001); chk("R2 default match", {5'd0, kind}, 2);
    dflt_en = 0; strobe(7'b1100001); chk("R2 default disabled", {7'd0, m}, 0);
    step(); chk("R5 single pulse", {7'd0, mv}, 0);
    strobe(7'b0001000); chk("R3 no host in device mode", {7'd0, m}, 0);
    host_mode = 1; strobe(7'b0001000); chk("R3 host match", {5'd0, kind}, 3);
    own_en = 0; strobe(7'h2a); chk("R1 own disabled", {7'd0, m}, 0);

    // R4 / R6 device alert
    host_mode = 0; alert_en = 1; step();
    chk("R6 drive asserted", {7'd0, drive}, 1);
    strobe(7'b0001100); chk("R4 ara match", {5'd0, kind}, 4);
    repeat (5) step();
    chk("R6 drive held", {7'd0, drive}, 1);
    alert_en = 0; step(); chk("R6 drive released", {7'd0, drive}, 0);
    strobe(7'b0001100); chk("R4 ara without enable", {7'd0, m}, 0);

    // R8 pin low with enable off, host mode
    host_mode = 1; pin = 0; repeat (5) step();
    chk("R8 no flag while disabled", {7'd0, flag}, 0);
    chk("R6 host never drives", {7'd0, drive}, 0);
    // R7 enabling with line already low counts as an edge
    alert_en = 1; step();
    chk("R7 enable-while-low edge", {7'd0, flag}, 1);
    errie = 1; step(); chk("R10 irq", {7'd0, irq}, 1);
    clr = 1; step(); clr = 0; chk("R9 cleared", {7'd0, flag}, 0);
    // R7 latency: falling edge
    pin = 1; repeat (4) step();
    pin = 0; step(); step();
    chk("R7 not yet after two edges", {7'd0, flag}, 0);
    clr = 1; step(); clr = 0;
    chk("R9 set wins over clear", {7'd0, flag}, 1);
    repeat (3) step(); chk("R9 sticky", {7'd0, flag}, 1);
    errie = 0; step(); chk("R10 irq masked", {7'd0, irq}, 0);
    clr = 1; step(); clr = 0;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 3) host_mode = ~host_mode;
      if (r >= 3 && r < 8) alert_en = ~alert_en;
      if (r >= 8 && r < 12) pin = ~pin;
      own_en  = ($urandom % 4) != 0;
      dflt_en = ($urandom % 2) != 0;
      errie   = ($urandom % 3) != 0;
      clr     = ($urandom % 10) == 0;
      addr_valid = ($urandom % 3) == 0;
      case ($urandom % 5)
        0: addr = own_addr;
        1: addr = 7'b1100001;
        2: addr = 7'b0001000;
        3: addr = 7'b0001100;
        default: addr = 7'($urandom);
      endcase
      step();
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule